// File: doc/BRIEF.md
# Inter-processor lock and mailbox channels

This block gives two processors a bank of hardware lock channels. Each processor reaches the block through its own register port, and the port number is the requester ID. A processor takes a channel by reading that channel's acquire register. The read reports whether the lock was granted. If the channel was free, the same read takes the lock and records the requester as owner. The owner gives the channel back by writing its release register.

Each channel also holds two data words that act as a mailbox. Either side may read or write these words at any time. A set of interrupt slots turns channel events into interrupt lines. A release or a notify on a channel carries a bitmask that selects slots. Each selected slot records the event in a status bit for that channel. Each slot has a mask register and write-one-to-clear status. Its line is the OR of all status bits that are masked in.

Register map (8-bit address). Address bit 7 = 0 selects a channel register. Bits [4:3] give the channel and bits [2:0] give the register: 0 acquire (read), 1 release (write), 2 notify (write), 3 mailbox word A, 4 mailbox word B, 5 lock state (read; bit 0 held, bit 1 owner ID). Address bit 7 = 1 selects an interrupt slot. Bits [2:2] give the slot and bits [1:0] give the register: 0 status (a read returns it, a write clears every bit written as one), 1 mask. Status and mask share one layout: bit c is the release event of channel c, and bit 4+c is the notify event of channel c. Release and notify writes select slots with data bits [1:0]. Read data appears on the port's read-data output one cycle after the request. It is zero for writes.

Top module: `ipc_lockbox`

## Requirements
- R1: A read of a free channel's acquire register (reg 0) returns 1 in bit 0. Afterwards the lock-state register (reg 5) reads held=1 (bit 0) and owner = the requesting port (bit 1).
- R2: A read of the acquire register of a held channel returns 0, and owner and held stay unchanged.
- R3: If both ports read the acquire register of the same free channel in the same cycle, port 0 gets 1 and port 1 gets 0, and port 0 becomes owner.
- R4: A release write (reg 1) from the owner clears the lock. In each slot selected by data bits [1:0], it sets status bit c (the release bit of that channel). Unselected slots are untouched.
- R5: A release write from a port that does not own the lock, or to a free channel, leaves the lock unchanged and sets no status bit.
- R6: A notify write (reg 2) sets status bit 4+c in each selected slot, whether the channel is held or free.
- R7: Each slot's interrupt line equals the OR of its status bits ANDed with its mask bits. It updates on the same clock edge as the status or mask change.
- R8: Writing ones to a slot's status register (reg 0) clears exactly those status bits.
- R9: Mailbox words A and B (regs 3 and 4) can be written and read by either port whether or not the lock is held, and by a port that is not the owner.
- R10: After synchronous reset, every lock is free, every status and mask bit is 0, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_valid | input | 1 | Port 0 request strobe |
| m0_write | input | 1 | Port 0 write (1) or read (0) |
| m0_addr | input | 8 | Port 0 register address |
| m0_wdata | input | 32 | Port 0 write data |
| m0_rdata | output | 32 | Port 0 read data, one cycle after the request |
| m1_valid | input | 1 | Port 1 request strobe |
| m1_write | input | 1 | Port 1 write (1) or read (0) |
| m1_addr | input | 8 | Port 1 register address |
| m1_wdata | input | 32 | Port 1 write data |
| m1_rdata | output | 32 | Port 1 read data, one cycle after the request |
| irq_o | output | 2 | One interrupt line per slot |

## Verification
The assertions check the following on every cycle:
- no simultaneous acquire hands the same lock to both ports;
- an owner never changes while a lock stays held;
- a lock drops only after a release write from its owner;
- every interrupt line matches its masked status;
- reset empties every lock.

Some behaviour only the directed scenarios can show. This covers the outcome of each contention, the slot bits set by release and notify masks, and releases from a port that does not own the lock being ignored. It also covers clearing through write-one-to-clear, and mailbox traffic by a port that is not the owner.

// File: rtl/ipc_lockbox_pkg.sv
package ipc_lockbox_pkg;
  localparam int NREQ = 2;

  typedef enum logic [2:0] {
    CR_ACQUIRE = 3'd0,
    CR_RELEASE = 3'd1,
    CR_NOTIFY  = 3'd2,
    CR_WORD_A  = 3'd3,
    CR_WORD_B  = 3'd4,
    CR_STATE   = 3'd5
  } chan_reg_e;

  typedef enum logic [1:0] {
    IR_STATUS = 2'd0,
    IR_MASK   = 2'd1
  } slot_reg_e;
endpackage

// File: rtl/ipc_lock_chan.sv
module ipc_lock_chan #(
  parameter int NREQ   = 2,
  parameter int DATA_W = 32,
  localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREQ-1:0]             acq_req,
  input  logic [NREQ-1:0]             rel_req,
  input  logic [NREQ-1:0]             dwr_en,
  input  logic [NREQ-1:0]             dwr_sel,
  input  logic [NREQ-1:0][DATA_W-1:0] dwr_data,
  output logic                        held,
  output logic [ID_W-1:0]             owner,
  output logic [NREQ-1:0]             acq_gnt,
  output logic                        rel_ok,
  output logic [ID_W-1:0]             rel_who,
  output logic [DATA_W-1:0]           word_a,
  output logic [DATA_W-1:0]           word_b
);
  logic [DATA_W-1:0] mbox [2];
  logic              taken;

  // lowest requester index wins a free lock
  always_comb begin
    acq_gnt = '0;
    taken   = 1'b0;
    for (int r = 0; r < NREQ; r++) begin
      if (acq_req[r] && !held && !taken) begin
        acq_gnt[r] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  always_comb begin
    rel_ok  = 1'b0;
    rel_who = owner;
    for (int r = 0; r < NREQ; r++) begin
      if (rel_req[r] && held && owner == ID_W'(r)) rel_ok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (rel_ok) begin
      held <= 1'b0;
    end else begin
      for (int r = NREQ - 1; r >= 0; r--) begin
        if (acq_gnt[r]) begin
          held  <= 1'b1;
          owner <= ID_W'(r);
        end
      end
    end
  end

  // mailbox kept free of reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    for (int r = NREQ - 1; r >= 0; r--) begin
      if (dwr_en[r]) mbox[dwr_sel[r]] <= dwr_data[r];
    end
  end

  assign word_a = mbox[0];
  assign word_b = mbox[1];
endmodule

// File: rtl/ipc_irq_slot.sv
module ipc_irq_slot #(
  parameter int NUM_CH = 4,
  parameter int NREQ   = 2,
  parameter int DATA_W = 32,
  localparam int SW    = 2 * NUM_CH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CH-1:0]           rel_set,
  input  logic [NUM_CH-1:0]           ntf_set,
  input  logic [NREQ-1:0]             mask_we,
  input  logic [NREQ-1:0]             clr_we,
  input  logic [NREQ-1:0][DATA_W-1:0] wdata,
  output logic [SW-1:0]               status,
  output logic [SW-1:0]               mask,
  output logic                        irq
);
  logic [SW-1:0] clr_bits, stat_d, mask_d;

  always_comb begin
    clr_bits = '0;
    mask_d   = mask;
    for (int r = NREQ - 1; r >= 0; r--) begin
      if (clr_we[r])  clr_bits = clr_bits | wdata[r][SW-1:0];
      if (mask_we[r]) mask_d   = wdata[r][SW-1:0];
    end
    // a new event wins over a clear in the same cycle
    stat_d = (status & ~clr_bits) | {ntf_set, rel_set};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= stat_d;
      mask   <= mask_d;
      irq    <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/ipc_lockbox.sv
module ipc_lockbox
  import ipc_lockbox_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_IRQ = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               m0_valid,
  input  logic               m0_write,
  input  logic [ADDR_W-1:0]  m0_addr,
  input  logic [DATA_W-1:0]  m0_wdata,
  output logic [DATA_W-1:0]  m0_rdata,
  input  logic               m1_valid,
  input  logic               m1_write,
  input  logic [ADDR_W-1:0]  m1_addr,
  input  logic [DATA_W-1:0]  m1_wdata,
  output logic [DATA_W-1:0]  m1_rdata,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int SW    = 2 * NUM_CH;

  logic [NREQ-1:0]             p_valid, p_write;
  logic [NREQ-1:0][ADDR_W-1:0] p_addr;
  logic [NREQ-1:0][DATA_W-1:0] p_wdata, rdata_q;

  assign p_valid  = {m1_valid, m0_valid};
  assign p_write  = {m1_write, m0_write};
  assign p_addr   = {m1_addr, m0_addr};
  assign p_wdata  = {m1_wdata, m0_wdata};
  assign m0_rdata = rdata_q[0];
  assign m1_rdata = rdata_q[1];

  // address decode per port
  logic [NREQ-1:0]            ch_rd, ch_wr, sl_rd, sl_wr, ch_ok, sl_ok;
  logic [NREQ-1:0][CH_W-1:0]  ch_idx;
  logic [NREQ-1:0][IRQ_W-1:0] sl_idx;
  logic [NREQ-1:0][2:0]       creg;
  logic [NREQ-1:0][1:0]       sreg;

  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      ch_idx[r] = p_addr[r][3 +: CH_W];
      sl_idx[r] = p_addr[r][2 +: IRQ_W];
      creg[r]   = p_addr[r][2:0];
      sreg[r]   = p_addr[r][1:0];
      ch_ok[r]  = int'(ch_idx[r]) < NUM_CH;
      sl_ok[r]  = int'(sl_idx[r]) < NUM_IRQ;
      ch_rd[r]  = p_valid[r] && !p_write[r] && !p_addr[r][ADDR_W-1];
      ch_wr[r]  = p_valid[r] &&  p_write[r] && !p_addr[r][ADDR_W-1];
      sl_rd[r]  = p_valid[r] && !p_write[r] &&  p_addr[r][ADDR_W-1];
      sl_wr[r]  = p_valid[r] &&  p_write[r] &&  p_addr[r][ADDR_W-1];
    end
  end

  logic [NUM_CH-1:0]                ch_held, rel_ok;
  logic [NUM_CH-1:0][ID_W-1:0]      ch_owner, rel_who;
  logic [NUM_CH-1:0][NREQ-1:0]      gnt;
  logic [NUM_CH-1:0][DATA_W-1:0]    ch_wa, ch_wb;
  logic [NUM_CH-1:0][NUM_IRQ-1:0]   rel_mask, ntf_mask;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [NREQ-1:0]    acq, rel, ntf, dwe, dsel;
    logic [NUM_IRQ-1:0] nm;

    always_comb begin
      nm = '0;
      for (int r = 0; r < NREQ; r++) begin
        acq[r]  = ch_rd[r] && ch_idx[r] == CH_W'(c) && creg[r] == CR_ACQUIRE;
        rel[r]  = ch_wr[r] && ch_idx[r] == CH_W'(c) && creg[r] == CR_RELEASE;
        ntf[r]  = ch_wr[r] && ch_idx[r] == CH_W'(c) && creg[r] == CR_NOTIFY;
        dwe[r]  = ch_wr[r] && ch_idx[r] == CH_W'(c) &&
                  (creg[r] == CR_WORD_A || creg[r] == CR_WORD_B);
        dsel[r] = creg[r] == CR_WORD_B;
        if (ntf[r]) nm = nm | p_wdata[r][NUM_IRQ-1:0];
      end
    end

    ipc_lock_chan #(.NREQ(NREQ), .DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .acq_req  (acq),
      .rel_req  (rel),
      .dwr_en   (dwe),
      .dwr_sel  (dsel),
      .dwr_data (p_wdata),
      .held     (ch_held[c]),
      .owner    (ch_owner[c]),
      .acq_gnt  (gnt[c]),
      .rel_ok   (rel_ok[c]),
      .rel_who  (rel_who[c]),
      .word_a   (ch_wa[c]),
      .word_b   (ch_wb[c])
    );

    assign ntf_mask[c] = nm;
    assign rel_mask[c] = rel_ok[c] ? p_wdata[rel_who[c]][NUM_IRQ-1:0] : '0;
  end

  // route channel events to slots
  logic [NUM_IRQ-1:0][NUM_CH-1:0] rel_route, ntf_route;
  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rel_route[k][c] = rel_mask[c][k];
        ntf_route[k][c] = ntf_mask[c][k];
      end
    end
  end

  logic [NUM_IRQ-1:0][SW-1:0] sl_stat, sl_mask;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_slot
    logic [NREQ-1:0] mwe, cwe;
    always_comb begin
      for (int r = 0; r < NREQ; r++) begin
        mwe[r] = sl_wr[r] && sl_idx[r] == IRQ_W'(k) && sreg[r] == IR_MASK;
        cwe[r] = sl_wr[r] && sl_idx[r] == IRQ_W'(k) && sreg[r] == IR_STATUS;
      end
    end

    ipc_irq_slot #(.NUM_CH(NUM_CH), .NREQ(NREQ), .DATA_W(DATA_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .rel_set (rel_route[k]),
      .ntf_set (ntf_route[k]),
      .mask_we (mwe),
      .clr_we  (cwe),
      .wdata   (p_wdata),
      .status  (sl_stat[k]),
      .mask    (sl_mask[k]),
      .irq     (irq_o[k])
    );
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      for (int r = 0; r < NREQ; r++) begin
        rdata_q[r] <= '0;
        if (ch_rd[r] && ch_ok[r]) begin
          case (creg[r])
            CR_ACQUIRE: rdata_q[r][0]      <= gnt[ch_idx[r]][r];
            CR_STATE:   rdata_q[r][ID_W:0] <= {ch_owner[ch_idx[r]], ch_held[ch_idx[r]]};
            CR_WORD_A:  rdata_q[r]         <= ch_wa[ch_idx[r]];
            CR_WORD_B:  rdata_q[r]         <= ch_wb[ch_idx[r]];
            default: ;
          endcase
        end else if (sl_rd[r] && sl_ok[r]) begin
          case (sreg[r])
            IR_STATUS: rdata_q[r][SW-1:0] <= sl_stat[sl_idx[r]];
            IR_MASK:   rdata_q[r][SW-1:0] <= sl_mask[sl_idx[r]];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ipc_lockbox_chk.sv
module ipc_lockbox_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_IRQ = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SW     = 2 * NUM_CH
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           m0_valid,
  input logic                           m0_write,
  input logic [ADDR_W-1:0]              m0_addr,
  input logic [DATA_W-1:0]              m0_rdata,
  input logic                           m1_valid,
  input logic                           m1_write,
  input logic [ADDR_W-1:0]              m1_addr,
  input logic [DATA_W-1:0]              m1_rdata,
  input logic [NUM_IRQ-1:0]             irq_o,
  input logic [NUM_CH-1:0]              held,
  input logic [NUM_CH-1:0][ID_W-1:0]    owner,
  input logic [NUM_IRQ-1:0][SW-1:0]     stat,
  input logic [NUM_IRQ-1:0][SW-1:0]     mask
);
  logic acq0, acq1, both_acq;
  assign acq0 = m0_valid && !m0_write && !m0_addr[ADDR_W-1] && m0_addr[2:0] == 3'd0;
  assign acq1 = m1_valid && !m1_write && !m1_addr[ADDR_W-1] && m1_addr[2:0] == 3'd0;
  assign both_acq = acq0 && acq1 && m0_addr[3 +: CH_W] == m1_addr[3 +: CH_W];

  // R3: one winner at most
  p_single_winner_r3: assert property (@(posedge clk) disable iff (rst)
    both_acq |=> !(m0_rdata[0] && m1_rdata[0]));

  // R10: reset frees every lock and quiets every line
  p_reset_clean_r10: assert property (@(posedge clk)
    rst |=> (held == '0 && irq_o == '0));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_k
    // R7: line follows masked status
    p_line_matches_r7: assert property (@(posedge clk) disable iff (rst)
      irq_o[k] == |(stat[k] & mask[k]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic rel0, rel1;
    assign rel0 = m0_valid && m0_write && !m0_addr[ADDR_W-1] &&
                  m0_addr[2:0] == 3'd1 && m0_addr[3 +: CH_W] == CH_W'(c);
    assign rel1 = m1_valid && m1_write && !m1_addr[ADDR_W-1] &&
                  m1_addr[2:0] == 3'd1 && m1_addr[3 +: CH_W] == CH_W'(c);

    // R2: owner fixed while held
    p_owner_steady_r2: assert property (@(posedge clk) disable iff (rst)
      (held[c] && $past(held[c])) |-> $stable(owner[c]));

    // R4 / R5: lock drops only on a release by its owner
    p_drop_by_owner_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(held[c]) |-> $past((rel0 && owner[c] == ID_W'(0)) ||
                               (rel1 && owner[c] == ID_W'(1))));
  end
endmodule

bind ipc_lockbox ipc_lockbox_chk #(
  .NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .m0_valid (m0_valid),
  .m0_write (m0_write),
  .m0_addr  (m0_addr),
  .m0_rdata (m0_rdata),
  .m1_valid (m1_valid),
  .m1_write (m1_write),
  .m1_addr  (m1_addr),
  .m1_rdata (m1_rdata),
  .irq_o    (irq_o),
  .held     (ch_held),
  .owner    (ch_owner),
  .stat     (sl_stat),
  .mask     (sl_mask)
);

// File: tb/ipc_lockbox_bench.sv
module ipc_lockbox_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m0_valid = 1'b0, m0_write = 1'b0;
  logic [7:0]  m0_addr = '0;
  logic [31:0] m0_wdata = '0, m0_rdata;
  logic        m1_valid = 1'b0, m1_write = 1'b0;
  logic [7:0]  m1_addr = '0;
  logic [31:0] m1_wdata = '0, m1_rdata;
  logic [1:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ipc_lockbox u_ipc_lockbox (
    .clk(clk), .rst(rst),
    .m0_valid(m0_valid), .m0_write(m0_write), .m0_addr(m0_addr),
    .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
    .m1_valid(m1_valid), .m1_write(m1_write), .m1_addr(m1_addr),
    .m1_wdata(m1_wdata), .m1_rdata(m1_rdata),
    .irq_o(irq_o)
  );

  function automatic logic [7:0] ca(input int c, input int r);
    return 8'((c << 3) | r);
  endfunction
  function automatic logic [7:0] sa(input int k, input int r);
    return 8'(8'h80 | (k << 2) | r);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input int p, input logic w, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    if (p == 0) begin m0_valid = 1; m0_write = w; m0_addr = a; m0_wdata = d; end
    else        begin m1_valid = 1; m1_write = w; m1_addr = a; m1_wdata = d; end
    @(negedge clk);
    m0_valid = 0; m1_valid = 0;
    rd = (p == 0) ? m0_rdata : m1_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    check("R10 irq lines", 32'(irq_o), 32'h0);
    xfer(0, 0, ca(0, 5), 0, rd); check("R10 lock state", rd, 32'h0);
    xfer(1, 0, sa(0, 0), 0, rd); check("R10 slot status", rd, 32'h0);
    xfer(1, 0, sa(1, 1), 0, rd); check("R10 slot mask", rd, 32'h0);
  endtask

  task automatic t_acquire();
    logic [31:0] rd;
    xfer(0, 0, ca(1, 0), 0, rd); check("R1 grant", rd, 32'h1);
    xfer(1, 0, ca(1, 5), 0, rd); check("R1 held by 0", rd, 32'h1);
    xfer(1, 0, ca(1, 0), 0, rd); check("R2 refused", rd, 32'h0);
    xfer(0, 0, ca(1, 5), 0, rd); check("R2 owner kept", rd, 32'h1);
  endtask

  task automatic t_foreign_release();
    logic [31:0] rd;
    xfer(1, 1, ca(1, 1), 32'h3, rd);
    xfer(0, 0, ca(1, 5), 0, rd); check("R5 lock kept", rd, 32'h1);
    xfer(0, 0, sa(0, 0), 0, rd); check("R5 no event slot0", rd, 32'h0);
    xfer(0, 0, sa(1, 0), 0, rd); check("R5 no event slot1", rd, 32'h0);
    xfer(0, 1, ca(2, 1), 32'h3, rd);
    xfer(0, 0, sa(0, 0), 0, rd); check("R5 free channel no event", rd, 32'h0);
  endtask

  task automatic t_release();
    logic [31:0] rd;
    xfer(1, 1, sa(0, 1), 32'hFF, rd);
    check("R7 mask alone no line", 32'(irq_o), 32'h0);
    xfer(0, 1, ca(1, 1), 32'h1, rd);
    check("R7 line up same edge", 32'(irq_o), 32'h1);
    xfer(0, 0, sa(0, 0), 0, rd); check("R4 release bit", rd, 32'h02);
    xfer(0, 0, sa(1, 0), 0, rd); check("R4 unselected slot", rd, 32'h0);
    xfer(1, 0, ca(1, 5), 0, rd); check("R4 lock freed", rd, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] rd;
    xfer(1, 1, sa(0, 0), 32'h02, rd);
    check("R8 line drops", 32'(irq_o), 32'h0);
    xfer(1, 0, sa(0, 0), 0, rd); check("R8 status cleared", rd, 32'h0);
  endtask

  task automatic t_notify();
    logic [31:0] rd;
    xfer(1, 1, ca(2, 2), 32'h2, rd);
    check("R7 unmasked stays low", 32'(irq_o), 32'h0);
    xfer(0, 0, sa(1, 0), 0, rd); check("R6 notify free channel", rd, 32'h40);
    xfer(0, 1, sa(1, 1), 32'h40, rd);
    check("R7 mask enables line", 32'(irq_o), 32'h2);
    xfer(0, 1, sa(1, 0), 32'h40, rd);
    xfer(0, 0, ca(2, 0), 0, rd);
    xfer(1, 1, ca(2, 2), 32'h3, rd);
    xfer(1, 0, sa(0, 0), 0, rd); check("R6 notify held channel slot0", rd, 32'h40);
    xfer(1, 0, sa(1, 0), 0, rd); check("R6 notify held channel slot1", rd, 32'h40);
    check("R6 lines", 32'(irq_o), 32'h3);
    xfer(0, 1, sa(0, 0), 32'hFF, rd);
    xfer(0, 1, sa(1, 0), 32'hFF, rd);
    xfer(0, 1, ca(2, 1), 32'h0, rd);
    check("R8 all clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_contend();
    logic [31:0] rd;
    @(negedge clk);
    m0_valid = 1; m0_write = 0; m0_addr = ca(3, 0);
    m1_valid = 1; m1_write = 0; m1_addr = ca(3, 0);
    @(negedge clk);
    m0_valid = 0; m1_valid = 0;
    check("R3 port0 wins", m0_rdata, 32'h1);
    check("R3 port1 loses", m1_rdata, 32'h0);
    xfer(1, 0, ca(3, 5), 0, rd); check("R3 owner 0", rd, 32'h1);
    xfer(0, 1, ca(3, 1), 32'h0, rd);
    xfer(1, 0, ca(3, 0), 0, rd); check("R1 port1 grant", rd, 32'h1);
    xfer(0, 0, ca(3, 5), 0, rd); check("R1 owner 1", rd, 32'h3);
  endtask

  task automatic t_mailbox();
    logic [31:0] rd;
    xfer(1, 0, ca(0, 0), 0, rd);
    xfer(0, 1, ca(0, 3), 32'hDEADBEEF, rd);
    xfer(1, 1, ca(0, 4), 32'h12345678, rd);
    xfer(0, 0, ca(0, 4), 0, rd); check("R9 word B by non-owner", rd, 32'h12345678);
    xfer(1, 0, ca(0, 3), 0, rd); check("R9 word A by owner", rd, 32'hDEADBEEF);
    xfer(0, 1, ca(2, 3), 32'hA5A5_0F0F, rd);
    xfer(1, 0, ca(2, 3), 0, rd); check("R9 word A free channel", rd, 32'hA5A5_0F0F);
    xfer(0, 0, ca(0, 3), 0, rd); check("R9 other channel intact", rd, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acquire();
    t_foreign_release();
    t_release();
    t_clear();
    t_notify();
    t_contend();
    t_mailbox();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule